// File: doc/BRIEF.md
# Pipelined Single-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two single-precision floating-point operands in a fixed four-stage pipeline and accepts a new operation on every clock. A control input selects addition or subtraction. Operands arrive with a valid strobe, and the result leaves four clocks later with its own valid strobe. Operations can be issued back to back with no gaps.

Stage one compares the operands and orders them by magnitude. Stage two aligns the smaller mantissa under the larger exponent. Stage three forms the sum or difference with one carry bit. Stage four renormalises the result. The mantissa path has two guard bits below the fraction. The result is truncated, never rounded. Denormal inputs, infinities and NaNs are outside the supported range. An exponent field of zero is always read as a zero operand.

Top module: `fp_addsub_pipe`

## Requirements
- R1: A result with `res_valid` high appears exactly four rising clock edges after the operands are captured with `op_valid` high. One operation is accepted per clock, and `res_valid` is low for every cycle with no matching issue.
- R2: When the two effective signs are equal, the result magnitude is the sum of the magnitudes and carries the common sign (e.g. 1.0 + 2.0 = 0x40400000).
- R3: With `op_sub` = 1 the result is `opa - opb`, which is done by inverting the sign bit (bit 31) of `opb`. With `op_sub` = 0 the result is `opa + opb`.
- R4: The operand with the larger magnitude gives the result its sign. Magnitude is ordered by the exponent field (bits 30:23) first and then by the fraction (bits 22:0). On a tie, `opa` counts as the larger.
- R5: If the exponent difference exceeds 25, the smaller operand contributes nothing and the result equals the larger operand (with its effective sign).
- R6: A carry out of the mantissa sum shifts the mantissa right by one and raises the exponent by one (1.0 + 1.0 = 0x40000000).
- R7: After a subtraction, the mantissa is shifted left by its leading-zero count and the exponent is lowered by the same count (1.5 - 1.25 = 0x3E800000).
- R8: A zero mantissa result is always positive zero, 0x00000000, including -0 + -0 and x - x.
- R9: An operand whose exponent field is 0 is treated as zero, whatever its fraction bits hold.
- R10: Result bits below the 23-bit fraction are discarded (truncation), after alignment with two guard bits (1.0 + 1.5*2^-23 = 0x3F800001).
- R11: If normalisation would bring the exponent to 0 or below, the result is positive zero.
- R12: After reset, `res_valid` is low and `res` is 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operands and select are valid this cycle |
| opa | input | 1+EXP_W+MAN_W | First operand |
| opb | input | 1+EXP_W+MAN_W | Second operand |
| op_sub | input | 1 | 1: opa - opb, 0: opa + opb |
| res_valid | output | 1 | Result is valid this cycle |
| res | output | 1+EXP_W+MAN_W | Sum or difference |

## Verification
With issues back to back, one stage can be renormalising a carry-out or a cancellation to zero while stage one accepts a fresh operand pair. That pair may need a full flush of its smaller operand. The bench keeps `op_valid` high for long random runs, with exponents chosen close together so that carries, cancellations and large shifts are mixed from cycle to cycle. Every result is compared with a reference model four cycles after its issue, and any mix-up between neighbouring operations shows up as a mismatch in a specific slot.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
   typedef enum logic [0:0] {MOP_ADD = 1'b0, MOP_SUB = 1'b1} mant_op_e;
   typedef enum logic [1:0] {NC_ZERO, NC_CARRY, NC_SHIFT} norm_case_e;
endpackage

// File: rtl/fpadd_s1_order.sv
module fpadd_s1_order #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   parameter int MW    = 26,
   parameter int SHW   = 5,
   localparam int W    = 1 + EXP_W + MAN_W,
   localparam int GRD  = MW - MAN_W - 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             v_i,
   input  logic [W-1:0]     a_i,
   input  logic [W-1:0]     b_i,
   input  logic             sub_i,
   output logic             v_q,
   output logic             sgn_big_q,
   output logic             sgn_sml_q,
   output logic [EXP_W-1:0] exp_big_q,
   output logic [MW-1:0]    man_big_q,
   output logic [MW-1:0]    man_sml_q,
   output logic [SHW-1:0]   shamt_q,
   output logic             flush_q
);
   logic [EXP_W-1:0] ea, eb, e_big, e_sml, diff;
   logic [MAN_W-1:0] fa, fb;
   logic             sa, sb, swap;
   logic [MW-1:0]    ma, mb;

   always_comb begin
      ea   = a_i[W-2 -: EXP_W];
      eb   = b_i[W-2 -: EXP_W];
      fa   = (ea == '0) ? '0 : a_i[MAN_W-1:0];
      fb   = (eb == '0) ? '0 : b_i[MAN_W-1:0];
      sa   = a_i[W-1];
      sb   = b_i[W-1] ^ sub_i;
      ma   = {(ea != '0), fa, {GRD{1'b0}}};
      mb   = {(eb != '0), fb, {GRD{1'b0}}};
      swap = {eb, fb} > {ea, fa};
      e_big = swap ? eb : ea;
      e_sml = swap ? ea : eb;
      diff  = e_big - e_sml;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         v_q       <= 1'b0;
         sgn_big_q <= 1'b0;
         sgn_sml_q <= 1'b0;
         exp_big_q <= '0;
         man_big_q <= '0;
         man_sml_q <= '0;
         shamt_q   <= '0;
         flush_q   <= 1'b0;
      end else begin
         v_q       <= v_i;
         sgn_big_q <= swap ? sb : sa;
         sgn_sml_q <= swap ? sa : sb;
         exp_big_q <= e_big;
         man_big_q <= swap ? mb : ma;
         man_sml_q <= swap ? ma : mb;
         shamt_q   <= diff[SHW-1:0];
         flush_q   <= (32'(diff) > 32'(MW - 1));
      end
   end
endmodule

// File: rtl/fpadd_s2_align.sv
module fpadd_s2_align #(
   parameter int EXP_W = 8,
   parameter int MW    = 26,
   parameter int SHW   = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             v_i,
   input  logic             sgn_big_i,
   input  logic             sgn_sml_i,
   input  logic [EXP_W-1:0] exp_big_i,
   input  logic [MW-1:0]    man_big_i,
   input  logic [MW-1:0]    man_sml_i,
   input  logic [SHW-1:0]   shamt_i,
   input  logic             flush_i,
   output logic             v_q,
   output logic             sgn_big_q,
   output logic             sgn_sml_q,
   output logic [EXP_W-1:0] exp_big_q,
   output logic [MW-1:0]    man_big_q,
   output logic [MW-1:0]    man_aln_q
);
   logic [MW-1:0] lvl [0:SHW];

   assign lvl[0] = man_sml_i;
   for (genvar g = 0; g < SHW; g++) begin : g_barrel
      assign lvl[g+1] = shamt_i[g] ? (lvl[g] >> (1 << g)) : lvl[g];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         v_q       <= 1'b0;
         sgn_big_q <= 1'b0;
         sgn_sml_q <= 1'b0;
         exp_big_q <= '0;
         man_big_q <= '0;
         man_aln_q <= '0;
      end else begin
         v_q       <= v_i;
         sgn_big_q <= sgn_big_i;
         sgn_sml_q <= sgn_sml_i;
         exp_big_q <= exp_big_i;
         man_big_q <= man_big_i;
         man_aln_q <= flush_i ? '0 : lvl[SHW];
      end
   end

   AST_FLUSH_ZERO: assert property (@(posedge clk) disable iff (rst)
      (v_i && flush_i) |=> (man_aln_q == '0)); // R5
endmodule

// File: rtl/fpadd_s3_sum.sv
module fpadd_s3_sum
   import fpadd_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MW    = 26
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             v_i,
   input  logic             sgn_big_i,
   input  logic             sgn_sml_i,
   input  logic [EXP_W-1:0] exp_big_i,
   input  logic [MW-1:0]    man_big_i,
   input  logic [MW-1:0]    man_aln_i,
   output logic             v_q,
   output logic             sgn_q,
   output logic [EXP_W-1:0] exp_q,
   output logic [MW:0]      sum_q
);
   mant_op_e op;
   logic [MW:0] sum_d;

   always_comb begin
      op    = (sgn_big_i ^ sgn_sml_i) ? MOP_SUB : MOP_ADD;
      sum_d = (op == MOP_SUB) ? ({1'b0, man_big_i} - {1'b0, man_aln_i})
                              : ({1'b0, man_big_i} + {1'b0, man_aln_i});
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         v_q   <= 1'b0;
         sgn_q <= 1'b0;
         exp_q <= '0;
         sum_q <= '0;
      end else begin
         v_q   <= v_i;
         sgn_q <= sgn_big_i;
         exp_q <= exp_big_i;
         sum_q <= sum_d;
      end
   end

   AST_NO_BORROW: assert property (@(posedge clk) disable iff (rst)
      (v_i && (sgn_big_i != sgn_sml_i)) |-> (man_big_i >= man_aln_i)); // R4
endmodule

// File: rtl/fpadd_s4_norm.sv
module fpadd_s4_norm
   import fpadd_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   parameter int MW    = 26,
   parameter int SHW   = 5,
   localparam int W    = 1 + EXP_W + MAN_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             v_i,
   input  logic             sgn_i,
   input  logic [EXP_W-1:0] exp_i,
   input  logic [MW:0]      sum_i,
   output logic             v_q,
   output logic [W-1:0]     res_q
);
   function automatic logic [SHW-1:0] lead_zeros(input logic [MW-1:0] x);
      logic [SHW-1:0] n;
      n = SHW'(MW);
      for (int i = 0; i < MW; i++)
         if (x[i]) n = SHW'(MW - 1 - i);
      return n;
   endfunction

   norm_case_e       nc;
   logic [SHW-1:0]   lz;
   logic [MW-1:0]    m_n;
   logic [EXP_W-1:0] e_n;
   logic [W-1:0]     res_d;

   always_comb begin
      lz  = lead_zeros(sum_i[MW-1:0]);
      m_n = '0;
      e_n = '0;
      if (sum_i == '0)
         nc = NC_ZERO;
      else if (sum_i[MW])
         nc = NC_CARRY;
      else if ({1'b0, exp_i} <= (EXP_W+1)'(lz))
         nc = NC_ZERO;
      else
         nc = NC_SHIFT;
      case (nc)
         NC_CARRY: begin
            m_n = sum_i[MW:1];
            e_n = exp_i + 1'b1;
         end
         NC_SHIFT: begin
            m_n = sum_i[MW-1:0] << lz;
            e_n = exp_i - EXP_W'(lz);
         end
         default: ;
      endcase
      res_d = (nc == NC_ZERO) ? '0 : {sgn_i, e_n, m_n[MW-2 -: MAN_W]};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         v_q   <= 1'b0;
         res_q <= '0;
      end else begin
         v_q   <= v_i;
         res_q <= res_d;
      end
   end

   AST_ZERO_POSITIVE: assert property (@(posedge clk) disable iff (rst)
      (v_q && (res_q[W-2:0] == '0)) |-> !res_q[W-1]); // R8
endmodule

// File: rtl/fp_addsub_pipe.sv
module fp_addsub_pipe #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   parameter int GUARD = 2,
   localparam int W    = 1 + EXP_W + MAN_W,
   localparam int MW   = MAN_W + 1 + GUARD,
   localparam int SHW  = $clog2(MW + 1)
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         op_valid,
   input  logic [W-1:0] opa,
   input  logic [W-1:0] opb,
   input  logic         op_sub,
   output logic         res_valid,
   output logic [W-1:0] res
);
   if (EXP_W < 3 || EXP_W > 15) begin : g_bad_exp
      $error("fp_addsub_pipe: EXP_W out of range");
   end
   if (MAN_W < 4 || GUARD < 1) begin : g_bad_man
      $error("fp_addsub_pipe: MAN_W or GUARD too small");
   end
   if (SHW > EXP_W) begin : g_bad_shw
      $error("fp_addsub_pipe: shift field wider than exponent");
   end

   logic             v1, sb1, ss1, fl1;
   logic [EXP_W-1:0] e1;
   logic [MW-1:0]    mb1, ms1;
   logic [SHW-1:0]   sh1;
   logic             v2, sb2, ss2;
   logic [EXP_W-1:0] e2;
   logic [MW-1:0]    mb2, ma2;
   logic             v3, s3;
   logic [EXP_W-1:0] e3;
   logic [MW:0]      sum3;

   fpadd_s1_order #(.EXP_W(EXP_W), .MAN_W(MAN_W), .MW(MW), .SHW(SHW)) u_s1 (
      .clk(clk), .rst(rst), .v_i(op_valid), .a_i(opa), .b_i(opb), .sub_i(op_sub),
      .v_q(v1), .sgn_big_q(sb1), .sgn_sml_q(ss1), .exp_big_q(e1),
      .man_big_q(mb1), .man_sml_q(ms1), .shamt_q(sh1), .flush_q(fl1));

   fpadd_s2_align #(.EXP_W(EXP_W), .MW(MW), .SHW(SHW)) u_s2 (
      .clk(clk), .rst(rst), .v_i(v1), .sgn_big_i(sb1), .sgn_sml_i(ss1),
      .exp_big_i(e1), .man_big_i(mb1), .man_sml_i(ms1), .shamt_i(sh1),
      .flush_i(fl1), .v_q(v2), .sgn_big_q(sb2), .sgn_sml_q(ss2),
      .exp_big_q(e2), .man_big_q(mb2), .man_aln_q(ma2));

   fpadd_s3_sum #(.EXP_W(EXP_W), .MW(MW)) u_s3 (
      .clk(clk), .rst(rst), .v_i(v2), .sgn_big_i(sb2), .sgn_sml_i(ss2),
      .exp_big_i(e2), .man_big_i(mb2), .man_aln_i(ma2),
      .v_q(v3), .sgn_q(s3), .exp_q(e3), .sum_q(sum3));

   fpadd_s4_norm #(.EXP_W(EXP_W), .MAN_W(MAN_W), .MW(MW), .SHW(SHW)) u_s4 (
      .clk(clk), .rst(rst), .v_i(v3), .sgn_i(s3), .exp_i(e3), .sum_i(sum3),
      .v_q(res_valid), .res_q(res));

   AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
      op_valid |-> ##4 res_valid); // R1
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
      !v3 |=> !res_valid); // R1
endmodule

// File: tb/fp_addsub_pipe_tb.sv
`timescale 1ns/1ps
module fp_addsub_pipe_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        op_valid = 1'b0;
   logic [31:0] opa = '0, opb = '0;
   logic        op_sub = 1'b0;
   logic        res_valid;
   logic [31:0] res;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic        pv [4];
   logic [31:0] pr [4];
   string       pt [4];

   always #2 clk = ~clk;

   fp_addsub_pipe u_dut (
      .clk(clk), .rst(rst), .op_valid(op_valid), .opa(opa), .opb(opb),
      .op_sub(op_sub), .res_valid(res_valid), .res(res));

   function automatic logic [31:0] ref_op(logic [31:0] a, logic [31:0] b, logic sub);
      longint unsigned ea, eb, fa, fb, eh, el, fh, fl, mh, ml, d, s, lz, e;
      logic sa, sb, sh, sl;
      ea = a[30:23]; eb = b[30:23];
      fa = (ea == 0) ? 0 : a[22:0];
      fb = (eb == 0) ? 0 : b[22:0];
      sa = a[31]; sb = b[31] ^ sub;
      if ((eb * 64'h800000 + fb) > (ea * 64'h800000 + fa)) begin
         eh = eb; fh = fb; sh = sb; el = ea; fl = fa; sl = sa;
      end else begin
         eh = ea; fh = fa; sh = sa; el = eb; fl = fb; sl = sb;
      end
      mh = (eh == 0) ? 0 : ((64'h800000 | fh) << 2);
      ml = (el == 0) ? 0 : ((64'h800000 | fl) << 2);
      d  = eh - el;
      ml = (d > 25) ? 0 : (ml >> d);
      s  = (sh == sl) ? (mh + ml) : (mh - ml);
      if (s == 0) return 32'h0;
      if (s >= 64'h4000000) begin
         s = s >> 1; e = eh + 1;
      end else begin
         lz = 0;
         while ((s & 64'h2000000) == 0) begin s = s << 1; lz++; end
         if (eh <= lz) return 32'h0;
         e = eh - lz;
      end
      return {sh, e[7:0], s[24:2]};
   endfunction

   task automatic check_out();
      checks++;
      if (res_valid !== pv[3]) begin
         errors++;
         $display("FAIL %s: res_valid actual %0b expected %0b", pt[3], res_valid, pv[3]);
      end else if (pv[3]) begin
         checks++;
         if (res !== pr[3]) begin
            errors++;
            $display("FAIL %s: res actual %h expected %h", pt[3], res, pr[3]);
         end
      end
   endtask

   task automatic step(input logic v, input logic [31:0] a, input logic [31:0] b,
                       input logic sub, input logic [31:0] expv, input string tag);
      @(negedge clk);
      check_out();
      for (int i = 3; i > 0; i--) begin
         pv[i] = pv[i-1]; pr[i] = pr[i-1]; pt[i] = pt[i-1];
      end
      pv[0] = v; pr[0] = expv; pt[0] = tag;
      op_valid = v; opa = a; opb = b; op_sub = sub;
   endtask

   task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic sub, input string tag);
      step(1'b1, a, b, sub, ref_op(a, b, sub), tag);
   endtask

   task automatic issue_lit(input logic [31:0] a, input logic [31:0] b, input logic sub,
                            input logic [31:0] lit, input string tag);
      step(1'b1, a, b, sub, lit, tag);
   endtask

   function automatic logic [31:0] rnd_op(int unsigned ebase);
      logic [31:0] x;
      x = $urandom;
      x[30:23] = 8'(ebase + ($urandom % 6));
      return x;
   endfunction

   initial begin
      int unsigned seed_val;
      for (int i = 0; i < 4; i++) begin pv[i] = 1'b0; pr[i] = '0; pt[i] = "R1"; end
      seed_val = $urandom(32'd20240611);
      repeat (3) @(negedge clk);
      // R12: reset state
      checks++;
      if (res_valid !== 1'b0 || res !== 32'h0) begin
         errors++;
         $display("FAIL R12: reset actual valid=%0b res=%h expected 0/00000000", res_valid, res);
      end
      rst = 1'b0;
      issue_lit(32'h3F800000, 32'h40000000, 1'b0, 32'h40400000, "R2");      // 1+2=3
      issue_lit(32'hBF800000, 32'hBF800000, 1'b0, 32'hC0000000, "R2");      // -1 + -1
      issue_lit(32'h40000000, 32'h40400000, 1'b1, 32'hBF800000, "R3");      // 2-3=-1
      issue_lit(32'h40000000, 32'hC0400000, 1'b0, 32'hBF800000, "R4");      // larger sets sign
      issue_lit(32'h40400000, 32'h40400000, 1'b1, 32'h00000000, "R4_tie");  // 3-3
      issue_lit(32'h3F800000, 32'h32800000, 1'b0, 32'h3F800000, "R5");      // diff 26 flushed
      issue_lit(32'h32800000, 32'h3F800000, 1'b1, 32'hBF800000, "R5_sub");
      issue_lit(32'h3F800000, 32'h3F800000, 1'b0, 32'h40000000, "R6");      // carry
      issue_lit(32'h3FC00000, 32'h3FA00000, 1'b1, 32'h3E800000, "R7");      // 1.5-1.25
      issue_lit(32'h80000000, 32'h80000000, 1'b0, 32'h00000000, "R8");      // -0 + -0
      issue_lit(32'hC0A00000, 32'hC0A00000, 1'b1, 32'h00000000, "R8_xx");
      issue_lit(32'h00400000, 32'h3F800000, 1'b0, 32'h3F800000, "R9");      // exp 0 operand
      issue_lit(32'h3F800000, 32'h807FFFFF, 1'b1, 32'h3F800000, "R9_sub");
      issue_lit(32'h3F800000, 32'h34400000, 1'b0, 32'h3F800001, "R10");     // truncation
      issue_lit(32'h00C00000, 32'h00800000, 1'b1, 32'h00000000, "R11");     // underflow
      step(1'b0, '0, '0, 1'b0, '0, "R1_gap");
      step(1'b0, '0, '0, 1'b0, '0, "R1_gap");
      // R1: long back-to-back random stream mixing carries, cancellations, flushes
      for (int n = 0; n < 3000; n++) begin
         int unsigned eb = 100 + ($urandom % 40);
         logic [31:0] a = rnd_op(eb);
         logic [31:0] b = ($urandom % 4 == 0) ? rnd_op(eb + 24) : rnd_op(eb);
         if ($urandom % 8 == 0) b = a;
         if ($urandom % 10 == 0)
            step(1'b0, a, b, 1'b0, '0, "R1_idle");
         else
            issue(a, b, 1'($urandom), "R1_rand");
      end
      repeat (5) step(1'b0, '0, '0, 1'b0, '0, "R1_drain");
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         errors++;
         $display("FAIL R1: watchdog expired actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule